// File: doc/BRIEF.md
# HOG Cell Orientation Histogram Generator

This block turns a raster stream of grey-level pixels into one nine-bin gradient orientation histogram for each non-overlapping 8×8 cell of the image. For every pixel it forms a horizontal and a vertical central difference. It adds their absolute values into a vote weight. It picks the orientation sector by comparing the vertical component against the horizontal one scaled by fixed-point tangents of the sector boundaries, so no angle or square root is ever formed. Two line buffers supply the rows above and below the centre row. Pixels outside the image are replaced by the nearest edge pixel.

Pixels arrive with a valid strobe, a start-of-frame marker on the first pixel of a frame and an end-of-line marker on the last pixel of each line. Valid may drop at any point inside a line. At least one idle cycle must follow every end-of-line pixel. At least `IMG_W + 4` idle cycles must follow the last line of a frame: during that time the block re-reads its line buffers to finish the bottom row. Each finished cell leaves as a one-cycle pulse that carries all nine bin sums and the cell's column and row index. Normalisation and classification are done downstream.

Top module: `hog_cell_hist`

## Requirements
- R1: With rows numbered downward, gx = p(r,c+1) − p(r,c−1) and gy = p(r+1,c) − p(r−1,c). A neighbour outside the image is replaced by the nearest pixel of the image on that axis.
- R2: The vote weight of a pixel is |gx| + |gy|, and a flat image gives all-zero histograms.
- R3: Before binning, when gx < 0, or when gx = 0 and gy < 0, both components are negated, so opposite gradients fall into the same bin.
- R4: The tangent constants are T = {93, 215, 443, 1452}, which are tan 20°, 40°, 60° and 80° with 8 fractional bits. Bins 0..8 cover 20° sectors starting at 0°. After folding, if gy ≥ 0 the bin is the number of T with 256·gy ≥ gx·T. Otherwise the bin is 8 minus the number of T with 256·|gy| > gx·T.
- R5: Bin k of a cell is the sum of the weights of its 64 pixels whose bin is k. It appears on `hist_bins[k*BIN_W +: BIN_W]`, with BIN_W = 15 at default parameters.
- R6: Every cell yields exactly one output per frame. Outputs come in raster order: cell rows top to bottom, and cell columns left to right within a row. `hist_cx` and `hist_cy` give the cell's column and row.
- R7: `hist_valid` is a single-cycle pulse and is never high in two consecutive cycles.
- R8: While reset is held, and after its release until new pixels arrive, `hist_valid` stays low. A reset in the middle of a frame discards all partial sums.
- R9: Idle cycles inside a line (valid low) do not change any histogram.
- R10: Frames may follow one another without reset, and each frame's histograms depend on its own pixels only.
- R11: The bottom cell row is issued during the blanking after the frame's last line, with no further pixel input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | PIX_W | Pixel intensity, unsigned |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a line |
| hist_valid | output | 1 | One-cycle pulse: a cell histogram is present |
| hist_bins | output | 9*BIN_W | Nine bin sums, bin k in slice k |
| hist_cx | output | CX_W | Cell column index |
| hist_cy | output | CY_W | Cell row index |

## Verification
A corrupted line buffer, a wrong edge-replication select, or a misplaced tail column shows up as wrong bin sums in the affected cell. The error reaches the port as soon as that cell closes, at most eight pixel rows later. A fault in the fold or tangent comparison moves weight between bins without changing a cell's total. For that reason every bin is compared against an independent model, using ramps in all quadrants and random frames. An accumulator that is not cleared, or a broken bottom-row replay, shows in the next frame's first cells, or as missing bottom-row cells within one blanking interval.

// File: rtl/hog_pkg.sv
// Package: constants shared by the cell histogram pipeline.
// Assumes orientation is unsigned (0..180 degrees) split into 20 degree bins.
package hog_pkg;
    localparam int NBINS    = 9;
    localparam int NEDGES   = 4;   // sector boundaries tested below 90 degrees
    localparam int TAN_FRAC = 8;   // fractional bits of the tangent constants
    localparam int BIN_IDX_W = 4;

    // Fixed-point tangent of boundary k (20, 40, 60, 80 degrees).
    function automatic int tan_edge(input int k);
        case (k)
            0:       return 93;
            1:       return 215;
            2:       return 443;
            default: return 1452;
        endcase
    endfunction
endpackage

// File: rtl/hog_line_window.sv
// Module: vertical window source.
// Turns the raster input into (above, centre, below) pixel triples for the centre
// row one line behind the input. Two line buffers hold the previous two rows.
// The top row replicates itself upward. After the last line it replays the buffers
// once so the bottom row is produced with itself as the row below.
// Assumes: well-formed lines of IMG_W pixels, IMG_H >= 2, and no pixel input
// during the replay (IMG_W + 2 cycles after the last end-of-line).
module hog_line_window #(
    parameter int IMG_W = 32,
    parameter int IMG_H = 16,
    parameter int PIX_W = 8,
    parameter int COL_W = 5,
    parameter int ROW_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             pix_sof,
    input  logic             pix_eol,
    output logic             win_valid,
    output logic [PIX_W-1:0] win_top,
    output logic [PIX_W-1:0] win_mid,
    output logic [PIX_W-1:0] win_bot,
    output logic [ROW_W-1:0] win_row,
    output logic [COL_W-1:0] win_col,
    output logic             win_last
);
    typedef enum logic [1:0] {RP_IDLE, RP_WAIT, RP_RUN} rp_state_t;

    logic [PIX_W-1:0] lb_prev1 [IMG_W];   // row r-1
    logic [PIX_W-1:0] lb_prev2 [IMG_W];   // row r-2
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] r_cur;
    logic [COL_W-1:0] c_cur;
    rp_state_t        rp_state;
    logic [COL_W-1:0] rp_cnt;
    logic             last_line;

    logic             src_vld;
    logic [PIX_W-1:0] src_top, src_mid, src_bot;
    logic [ROW_W-1:0] src_row;
    logic [COL_W-1:0] src_col;
    logic             src_last;

    // Position of the current input pixel; start-of-frame forces the origin.
    always_comb begin
        r_cur     = pix_sof ? '0 : row_q;
        c_cur     = pix_sof ? '0 : col_q;
        last_line = (r_cur == ROW_W'(IMG_H - 1));
    end

    // Choose the window source: replay of the buffers, or live input.
    always_comb begin
        src_vld  = 1'b0;
        src_top  = '0;
        src_mid  = '0;
        src_bot  = '0;
        src_row  = '0;
        src_col  = '0;
        src_last = 1'b0;
        if (rp_state == RP_RUN) begin
            src_vld  = 1'b1;
            src_top  = lb_prev2[rp_cnt];
            src_mid  = lb_prev1[rp_cnt];
            src_bot  = lb_prev1[rp_cnt];
            src_row  = ROW_W'(IMG_H - 1);
            src_col  = rp_cnt;
            src_last = (rp_cnt == COL_W'(IMG_W - 1));
        end else if (pix_valid && (r_cur != '0)) begin
            src_vld  = 1'b1;
            src_top  = (r_cur == ROW_W'(1)) ? lb_prev1[c_cur] : lb_prev2[c_cur];
            src_mid  = lb_prev1[c_cur];
            src_bot  = pix_data;
            src_row  = r_cur - ROW_W'(1);
            src_col  = c_cur;
            src_last = pix_eol;
        end
    end

    // Shift the new pixel into the two line buffers at its column.
    always_ff @(posedge clk) begin
        if (pix_valid && (rp_state != RP_RUN)) begin
            lb_prev2[c_cur] <= lb_prev1[c_cur];
            lb_prev1[c_cur] <= pix_data;
        end
    end

    // Track the raster position of the input stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (pix_valid) begin
            if (pix_eol) begin
                row_q <= r_cur + ROW_W'(1);
                col_q <= '0;
            end else begin
                row_q <= r_cur;
                col_q <= c_cur + COL_W'(1);
            end
        end
    end

    // Bottom-row replay sequencer: one gap cycle, then IMG_W reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_state <= RP_IDLE;
            rp_cnt   <= '0;
        end else begin
            case (rp_state)
                RP_IDLE: if (pix_valid && pix_eol && last_line) rp_state <= RP_WAIT;
                RP_WAIT: begin
                    rp_state <= RP_RUN;
                    rp_cnt   <= '0;
                end
                RP_RUN: begin
                    rp_cnt <= rp_cnt + COL_W'(1);
                    if (rp_cnt == COL_W'(IMG_W - 1)) rp_state <= RP_IDLE;
                end
                default: rp_state <= RP_IDLE;
            endcase
        end
    end

    // Register the chosen window for the gradient stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            win_top   <= '0;
            win_mid   <= '0;
            win_bot   <= '0;
            win_row   <= '0;
            win_col   <= '0;
            win_last  <= 1'b0;
        end else begin
            win_valid <= src_vld;
            win_top   <= src_top;
            win_mid   <= src_mid;
            win_bot   <= src_bot;
            win_row   <= src_row;
            win_col   <= src_col;
            win_last  <= src_last;
        end
    end
endmodule

// File: rtl/hog_grad.sv
// Module: central-difference gradient stage.
// Produces gx and gy for the column one behind the incoming window column.
// The left edge reuses the centre pixel as its left neighbour. The rightmost
// column is finished in the idle cycle that follows a line's last window.
// Assumes: the window after one flagged last is invalid.
module hog_grad #(
    parameter int PIX_W = 8,
    parameter int COL_W = 5,
    parameter int ROW_W = 5,
    localparam int GW   = PIX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 win_valid,
    input  logic [PIX_W-1:0]     win_top,
    input  logic [PIX_W-1:0]     win_mid,
    input  logic [PIX_W-1:0]     win_bot,
    input  logic [ROW_W-1:0]     win_row,
    input  logic [COL_W-1:0]     win_col,
    input  logic                 win_last,
    output logic                 g_valid,
    output logic signed [GW-1:0] g_x,
    output logic signed [GW-1:0] g_y,
    output logic [ROW_W-1:0]     g_row,
    output logic [COL_W-1:0]     g_col
);
    logic [PIX_W-1:0]     mid_d1, mid_d2;   // centre pixels at col-1, col-2
    logic signed [GW-1:0] dy_d1;            // vertical difference at col-1
    logic [ROW_W-1:0]     row_d1;
    logic [COL_W-1:0]     col_d1;
    logic                 tail_pend;

    logic                 emit;
    logic signed [GW-1:0] gx_n;
    logic signed [GW-1:0] dy_now;
    logic [PIX_W-1:0]     right_px, left_px;

    // Form the gradient of the previous column from the neighbours held so far.
    always_comb begin
        dy_now   = $signed({1'b0, win_bot}) - $signed({1'b0, win_top});
        emit     = 1'b0;
        right_px = mid_d1;
        left_px  = mid_d2;
        if (win_valid && (win_col != '0)) begin
            emit     = 1'b1;
            right_px = win_mid;
            left_px  = (win_col == COL_W'(1)) ? mid_d1 : mid_d2;
        end else if (tail_pend) begin
            emit     = 1'b1;
            right_px = mid_d1;
            left_px  = mid_d2;
        end
        gx_n = $signed({1'b0, right_px}) - $signed({1'b0, left_px});
    end

    // Keep a two-column history of the centre row and the vertical difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_d1    <= '0;
            mid_d2    <= '0;
            dy_d1     <= '0;
            row_d1    <= '0;
            col_d1    <= '0;
            tail_pend <= 1'b0;
        end else begin
            tail_pend <= win_valid && win_last;
            if (win_valid) begin
                mid_d2 <= mid_d1;
                mid_d1 <= win_mid;
                dy_d1  <= dy_now;
                row_d1 <= win_row;
                col_d1 <= win_col;
            end
        end
    end

    // Register the gradient pair with its pixel position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_valid <= 1'b0;
            g_x     <= '0;
            g_y     <= '0;
            g_row   <= '0;
            g_col   <= '0;
        end else begin
            g_valid <= emit;
            g_x     <= gx_n;
            g_y     <= dy_d1;
            g_row   <= row_d1;
            g_col   <= col_d1;
        end
    end
endmodule

// File: rtl/hog_bin_sel.sv
// Module: orientation bin selector and vote weight.
// Folds the gradient into the right half-plane and counts how many sector
// boundaries the vertical component passes, using products with fixed-point
// tangents. The weight is the L1 magnitude.
// Assumes: |gx|, |gy| < 2**PIX_W.
module hog_bin_sel
    import hog_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int COL_W = 5,
    parameter int ROW_W = 5,
    localparam int GW    = PIX_W + 1,
    localparam int MAG_W = PIX_W + 1,
    localparam int PW    = PIX_W + TAN_FRAC + 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 g_valid,
    input  logic signed [GW-1:0] g_x,
    input  logic signed [GW-1:0] g_y,
    input  logic [ROW_W-1:0]     g_row,
    input  logic [COL_W-1:0]     g_col,
    output logic                 v_valid,
    output logic [BIN_IDX_W-1:0] v_bin,
    output logic [MAG_W-1:0]     v_mag,
    output logic [ROW_W-1:0]     v_row,
    output logic [COL_W-1:0]     v_col
);
    logic                 flip;
    logic signed [GW-1:0] fx, fy, neg_fy;
    logic [PIX_W-1:0]     ax, ay;
    logic [PW-1:0]        lhs;
    logic [NEDGES-1:0]    ge, gt;
    logic [2:0]           cnt_ge, cnt_gt;
    logic [BIN_IDX_W-1:0] bin_n;

    // Fold into gx >= 0 and take magnitudes of both components.
    always_comb begin
        flip   = (g_x < 0) || ((g_x == 0) && (g_y < 0));
        fx     = flip ? -g_x : g_x;
        fy     = flip ? -g_y : g_y;
        neg_fy = -fy;
        ax     = fx[PIX_W-1:0];
        ay     = (fy < 0) ? neg_fy[PIX_W-1:0] : fy[PIX_W-1:0];
        lhs    = PW'(ay) << TAN_FRAC;
    end

    // One comparator pair per sector boundary.
    for (genvar k = 0; k < NEDGES; k++) begin : g_edge
        logic [PW-1:0] rhs;
        assign rhs   = PW'(ax) * PW'(tan_edge(k));
        assign ge[k] = (lhs >= rhs);
        assign gt[k] = (lhs > rhs);
    end

    // Count passed boundaries and map them onto the 0..8 bin index.
    always_comb begin
        cnt_ge = '0;
        cnt_gt = '0;
        for (int k = 0; k < NEDGES; k++) begin
            cnt_ge = cnt_ge + {2'b00, ge[k]};
            cnt_gt = cnt_gt + {2'b00, gt[k]};
        end
        if (fy < 0) bin_n = BIN_IDX_W'(NBINS - 1) - {1'b0, cnt_gt};
        else        bin_n = {1'b0, cnt_ge};
    end

    // Register the vote.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_valid <= 1'b0;
            v_bin   <= '0;
            v_mag   <= '0;
            v_row   <= '0;
            v_col   <= '0;
        end else begin
            v_valid <= g_valid;
            v_bin   <= bin_n;
            v_mag   <= MAG_W'(ax) + MAG_W'(ay);
            v_row   <= g_row;
            v_col   <= g_col;
        end
    end
endmodule

// File: rtl/hog_cell_accum.sv
// Module: per-cell histogram accumulator.
// Holds one set of bin sums for each cell column of the current cell row. The
// vote of a cell's bottom-right pixel completes it: the sums plus that vote are
// issued and the slot is cleared for the next cell row.
// Assumes: votes arrive in raster order of pixel positions.
module hog_cell_accum
    import hog_pkg::*;
#(
    parameter int IMG_W   = 32,
    parameter int CELL_LG = 3,
    parameter int MAG_W   = 9,
    parameter int BIN_W   = 15,
    parameter int COL_W   = 5,
    parameter int ROW_W   = 5,
    parameter int CX_W    = 2,
    parameter int CY_W    = 1,
    localparam int NCX    = IMG_W >> CELL_LG
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   v_valid,
    input  logic [BIN_IDX_W-1:0]   v_bin,
    input  logic [MAG_W-1:0]       v_mag,
    input  logic [ROW_W-1:0]       v_row,
    input  logic [COL_W-1:0]       v_col,
    output logic                   hist_valid,
    output logic [NBINS*BIN_W-1:0] hist_bins,
    output logic [CX_W-1:0]        hist_cx,
    output logic [CY_W-1:0]        hist_cy
);
    logic [BIN_W-1:0] acc [NCX][NBINS];
    logic [BIN_W-1:0] sums [NBINS];
    logic [CX_W-1:0]  cx;
    logic [CY_W-1:0]  cy;
    logic             cell_done;

    // Add the vote to its bin and detect the cell's final pixel.
    always_comb begin
        cx        = CX_W'(v_col >> CELL_LG);
        cy        = CY_W'(v_row >> CELL_LG);
        cell_done = (&v_col[CELL_LG-1:0]) && (&v_row[CELL_LG-1:0]);
        for (int k = 0; k < NBINS; k++) begin
            sums[k] = acc[cx][k] + ((v_bin == BIN_IDX_W'(k)) ? BIN_W'(v_mag) : '0);
        end
    end

    // Update the slot, or issue and clear it when the cell completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCX; c++) begin
                for (int k = 0; k < NBINS; k++) acc[c][k] <= '0;
            end
            hist_valid <= 1'b0;
            hist_bins  <= '0;
            hist_cx    <= '0;
            hist_cy    <= '0;
        end else begin
            hist_valid <= v_valid && cell_done;
            if (v_valid) begin
                for (int k = 0; k < NBINS; k++) begin
                    acc[cx][k] <= cell_done ? '0 : sums[k];
                end
                if (cell_done) begin
                    for (int k = 0; k < NBINS; k++) hist_bins[k*BIN_W +: BIN_W] <= sums[k];
                    hist_cx <= cx;
                    hist_cy <= cy;
                end
            end
        end
    end
endmodule

// File: rtl/hog_cell_hist.sv
// Module: top of the cell orientation histogram generator.
// Chains window source, gradient, bin selection and cell accumulation.
// Assumes: IMG_W and IMG_H are multiples of the cell size, one idle cycle after
// each end-of-line, and at least IMG_W + 4 idle cycles after a frame.
module hog_cell_hist
    import hog_pkg::*;
#(
    parameter int IMG_W   = 32,
    parameter int IMG_H   = 16,
    parameter int PIX_W   = 8,
    parameter int CELL_LG = 3,
    localparam int CELL   = 1 << CELL_LG,
    localparam int NCX    = IMG_W / CELL,
    localparam int NCY    = IMG_H / CELL,
    localparam int COL_W  = $clog2(IMG_W),
    localparam int ROW_W  = $clog2(IMG_H) + 1,
    localparam int GW     = PIX_W + 1,
    localparam int MAG_W  = PIX_W + 1,
    localparam int BIN_W  = MAG_W + 2 * CELL_LG,
    localparam int CX_W   = (NCX > 1) ? $clog2(NCX) : 1,
    localparam int CY_W   = (NCY > 1) ? $clog2(NCY) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pix_valid,
    input  logic [PIX_W-1:0]       pix_data,
    input  logic                   pix_sof,
    input  logic                   pix_eol,
    output logic                   hist_valid,
    output logic [NBINS*BIN_W-1:0] hist_bins,
    output logic [CX_W-1:0]        hist_cx,
    output logic [CY_W-1:0]        hist_cy
);
    logic                 win_valid, win_last;
    logic [PIX_W-1:0]     win_top, win_mid, win_bot;
    logic [ROW_W-1:0]     win_row, g_row, v_row;
    logic [COL_W-1:0]     win_col, g_col, v_col;
    logic                 g_valid, v_valid;
    logic signed [GW-1:0] g_x, g_y;
    logic [BIN_IDX_W-1:0] v_bin;
    logic [MAG_W-1:0]     v_mag;

    hog_line_window #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W), .COL_W(COL_W), .ROW_W(ROW_W)
    ) u_window (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_sof(pix_sof), .pix_eol(pix_eol),
        .win_valid(win_valid), .win_top(win_top), .win_mid(win_mid), .win_bot(win_bot),
        .win_row(win_row), .win_col(win_col), .win_last(win_last)
    );

    hog_grad #(
        .PIX_W(PIX_W), .COL_W(COL_W), .ROW_W(ROW_W)
    ) u_grad (
        .clk(clk), .rst_n(rst_n),
        .win_valid(win_valid), .win_top(win_top), .win_mid(win_mid), .win_bot(win_bot),
        .win_row(win_row), .win_col(win_col), .win_last(win_last),
        .g_valid(g_valid), .g_x(g_x), .g_y(g_y), .g_row(g_row), .g_col(g_col)
    );

    hog_bin_sel #(
        .PIX_W(PIX_W), .COL_W(COL_W), .ROW_W(ROW_W)
    ) u_bin (
        .clk(clk), .rst_n(rst_n),
        .g_valid(g_valid), .g_x(g_x), .g_y(g_y), .g_row(g_row), .g_col(g_col),
        .v_valid(v_valid), .v_bin(v_bin), .v_mag(v_mag), .v_row(v_row), .v_col(v_col)
    );

    hog_cell_accum #(
        .IMG_W(IMG_W), .CELL_LG(CELL_LG), .MAG_W(MAG_W), .BIN_W(BIN_W),
        .COL_W(COL_W), .ROW_W(ROW_W), .CX_W(CX_W), .CY_W(CY_W)
    ) u_accum (
        .clk(clk), .rst_n(rst_n),
        .v_valid(v_valid), .v_bin(v_bin), .v_mag(v_mag), .v_row(v_row), .v_col(v_col),
        .hist_valid(hist_valid), .hist_bins(hist_bins), .hist_cx(hist_cx), .hist_cy(hist_cy)
    );
endmodule

// File: rtl/hog_cell_hist_chk.sv
// Module: assertion checker for the histogram generator, bound to its top.
// Watches the output pulse, per-cell weight capacity and raster order of cells.
module hog_cell_hist_chk #(
    parameter int NBINS = 9,
    parameter int BIN_W = 15,
    parameter int CX_W  = 2,
    parameter int CY_W  = 1,
    parameter int CAP   = 32640
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   hist_valid,
    input logic [NBINS*BIN_W-1:0] hist_bins,
    input logic [CX_W-1:0]        hist_cx,
    input logic [CY_W-1:0]        hist_cy
);
    logic [BIN_W+3:0] total;
    logic             seen;
    logic [CX_W-1:0]  prev_cx;
    logic [CY_W-1:0]  prev_cy;

    // Sum of all bins of the presented cell.
    always_comb begin
        total = '0;
        for (int k = 0; k < NBINS; k++) total = total + (BIN_W+4)'(hist_bins[k*BIN_W +: BIN_W]);
    end

    // Remember the last issued cell position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen    <= 1'b0;
            prev_cx <= '0;
            prev_cy <= '0;
        end else if (hist_valid) begin
            seen    <= 1'b1;
            prev_cx <= hist_cx;
            prev_cy <= hist_cy;
        end
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hist_valid |=> !hist_valid);                                          // R7
    AST_CELL_CAPACITY: assert property (@(posedge clk) disable iff (!rst_n)
        hist_valid |-> (total <= (BIN_W+4)'(CAP)));                          // R5
    AST_COL_SEQUENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_valid && seen && (hist_cy == prev_cy)) |-> (hist_cx == prev_cx + CX_W'(1))); // R6
    AST_ROW_START: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_valid && seen && (hist_cy != prev_cy)) |-> (hist_cx == '0));  // R6
endmodule

bind hog_cell_hist hog_cell_hist_chk #(
    .NBINS(hog_pkg::NBINS), .BIN_W(BIN_W), .CX_W(CX_W), .CY_W(CY_W),
    .CAP(CELL * CELL * 2 * ((1 << PIX_W) - 1))
) u_chk (
    .clk(clk), .rst_n(rst_n), .hist_valid(hist_valid), .hist_bins(hist_bins),
    .hist_cx(hist_cx), .hist_cy(hist_cy)
);

// File: tb/hog_cell_hist_tb.sv
module hog_cell_hist_tb;
    localparam int IMG_W = 32, IMG_H = 16, PIX_W = 8, CELL = 8;
    localparam int NCX = IMG_W / CELL, NCY = IMG_H / CELL, NCELL = NCX * NCY;
    localparam int NB = 9, BIN_W = 15;
    // Pattern table: slope x, slope y, base, bubbles, random seed.
    localparam int NPAT = 9;
    localparam int PAT [NPAT][5] = '{
        '{ 3,  0,  10, 0, 0},
        '{ 0,  3,  40, 0, 0},
        '{ 2,  2,   0, 0, 0},
        '{-3,  1, 200, 0, 0},
        '{ 1, -4,  90, 1, 0},
        '{ 5, -1,   7, 0, 0},
        '{ 0,  0,  77, 0, 0},
        '{ 0,  0,   0, 1, 1},
        '{ 0,  0,   0, 0, 2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_valid = 1'b0, pix_sof = 1'b0, pix_eol = 1'b0;
    logic [PIX_W-1:0] pix_data = '0;
    logic hist_valid;
    logic [NB*BIN_W-1:0] hist_bins;
    logic [1:0] hist_cx;
    logic [0:0] hist_cy;

    always #5 clk = ~clk;

    hog_cell_hist u_dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_sof(pix_sof), .pix_eol(pix_eol), .hist_valid(hist_valid),
        .hist_bins(hist_bins), .hist_cx(hist_cx), .hist_cy(hist_cy)
    );

    int n_chk = 0, n_bad = 0;
    int img [IMG_H][IMG_W];
    int exp_b [NCELL][NB];
    int cap_b [16][NB];
    int cap_cx [16], cap_cy [16];
    int cap_n = 0, dbl_n = 0;
    logic prev_hv = 1'b0;

    // Capture output pulses away from the active edge.
    always @(negedge clk) begin
        if (hist_valid) begin
            if (cap_n < 16) begin
                for (int k = 0; k < NB; k++) cap_b[cap_n][k] = int'(hist_bins[k*BIN_W +: BIN_W]);
                cap_cx[cap_n] = int'(hist_cx);
                cap_cy[cap_n] = int'(hist_cy);
            end
            cap_n++;
        end
        if (hist_valid && prev_hv) dbl_n++;
        prev_hv = hist_valid;
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int ref_bin(input int gx_in, input int gy_in);
        int gx = gx_in, gy = gy_in, cnt = 0;
        int t [4] = '{93, 215, 443, 1452};
        if (gx < 0 || (gx == 0 && gy < 0)) begin gx = -gx; gy = -gy; end
        if (gy >= 0) begin
            for (int k = 0; k < 4; k++) if (256 * gy >= gx * t[k]) cnt++;
            return cnt;
        end
        for (int k = 0; k < 4; k++) if (256 * (-gy) > gx * t[k]) cnt++;
        return 8 - cnt;
    endfunction

    function automatic int clampi(input int v, input int hi);
        return (v < 0) ? 0 : ((v > hi) ? hi : v);
    endfunction

    task automatic build(input int a, input int b, input int base, input int seed);
        logic [15:0] lf = 16'hACE1 ^ 16'(seed * 977);
        for (int r = 0; r < IMG_H; r++) begin
            for (int c = 0; c < IMG_W; c++) begin
                int noise = 0;
                if (seed != 0) begin
                    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    noise = int'(lf[7:0]);
                end
                img[r][c] = (base + a * c + b * r + noise) & 255;
            end
        end
        for (int i = 0; i < NCELL; i++) for (int k = 0; k < NB; k++) exp_b[i][k] = 0;
        for (int r = 0; r < IMG_H; r++) begin
            for (int c = 0; c < IMG_W; c++) begin
                int gx = img[r][clampi(c + 1, IMG_W - 1)] - img[r][clampi(c - 1, IMG_W - 1)];
                int gy = img[clampi(r + 1, IMG_H - 1)][c] - img[clampi(r - 1, IMG_H - 1)][c];
                int mg = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
                exp_b[(r / CELL) * NCX + c / CELL][ref_bin(gx, gy)] += mg;
            end
        end
    endtask

    task automatic drive_rows(input int nrows, input bit bubble);
        for (int r = 0; r < nrows; r++) begin
            for (int c = 0; c < IMG_W; c++) begin
                @(negedge clk);
                pix_valid = 1'b1;
                pix_data  = PIX_W'(img[r][c]);
                pix_sof   = (r == 0 && c == 0);
                pix_eol   = (c == IMG_W - 1);
                if (bubble && (c % 3 == 2)) begin
                    @(negedge clk);
                    pix_valid = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0;
                end
            end
            @(negedge clk);
            pix_valid = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0;
        end
    endtask

    task automatic run_frame(input bit bubble);
        cap_n = 0;
        drive_rows(IMG_H, bubble);
        repeat (IMG_W + 6) @(negedge clk);
    endtask

    task automatic check_frame(input string req);
        int bottom = 0;
        check(cap_n == NCELL, "R6", "cell count", cap_n, NCELL);
        for (int i = 0; i < NCELL && i < cap_n; i++) begin
            bit ok = 1'b1;
            int bad_k = 0;
            for (int k = NB - 1; k >= 0; k--) if (cap_b[i][k] != exp_b[i][k]) begin ok = 1'b0; bad_k = k; end
            check(ok, req, $sformatf("cell %0d bin %0d", i, bad_k), cap_b[i][bad_k], exp_b[i][bad_k]);
            check(cap_cx[i] == i % NCX && cap_cy[i] == i / NCX, "R6", $sformatf("cell %0d index", i),
                  cap_cy[i] * 100 + cap_cx[i], (i / NCX) * 100 + i % NCX);
            if (cap_cy[i] == NCY - 1) bottom++;
        end
        check(bottom == NCX, "R11", "bottom row cells", bottom, NCX);
    endtask

    function automatic string pat_req(input int i);
        case (i)
            0, 1:    return "R1";
            2, 8:    return "R4";
            3:       return "R3";
            4, 7:    return "R9";
            default: return "R2";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R8: quiet during and after reset
        repeat (4) @(negedge clk);
        check(hist_valid == 1'b0, "R8", "valid in reset", int'(hist_valid), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(cap_n == 0, "R8", "pulses after reset", cap_n, 0);

        // Pattern table, frames back to back without reset
        for (int p = 0; p < NPAT; p++) begin
            build(PAT[p][0], PAT[p][1], PAT[p][2], PAT[p][4]);
            run_frame(PAT[p][3] != 0);
            check_frame(pat_req(p));
        end

        // R10: repeat a ramp right after a random frame
        build(PAT[0][0], PAT[0][1], PAT[0][2], 0);
        run_frame(1'b0);
        check_frame("R10");

        // R8: reset in the middle of a frame drops partial sums
        build(0, 0, 0, 5);
        drive_rows(9, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        build(PAT[2][0], PAT[2][1], PAT[2][2], 0);
        run_frame(1'b0);
        check_frame("R8");

        // R7: no two-cycle pulses over the whole run
        check(dbl_n == 0, "R7", "back-to-back valid", dbl_n, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule